// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits on the inbound memory-write path of a host bridge and turns message-signalled interrupt writes into pending bits. Software programs a 64-bit target address. Each inbound write whose full address equals that target is a message, and its data word is taken as a vector number. The vector selects one pending bit out of `NUM_BANKS` banks of 32 bits. Every other inbound write is not a message: it is forwarded unchanged on a registered pass-through port.

Software controls each bank through three 32-bit registers on a simple register port. The enable register admits vectors, the mask register gates them onto the interrupt line, and the status register holds the pending bits and is cleared by writing ones. One registered interrupt output is high while any pending vector is unmasked.

With the default parameters there are 8 banks, which gives 256 vectors.

Top module: `msi_capture_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq_out` is 0 and `pt_valid` is 0.
- R2: The low and high halves of the target address are read/write at register offsets 0x820 and 0x824. A valid inbound write whose 64-bit address equals the target, whose data value v is below 256 and whose vector is enabled sets status bit v%32 of bank v/32 at the next clock edge.
- R3: Bank n (0..7) has its enable register at 0x828+12n, its mask register at 0x82C+12n and its status register at 0x830+12n. Enable and mask are plain read/write. A read of any other offset, including an offset that is not a multiple of 4, returns 0, and a write to such an offset changes nothing.
- R4: A message for a vector whose enable bit is 0 sets no status bit.
- R5: A message whose data value is 256 or more sets no status bit and is not forwarded.
- R6: An inbound write whose address differs from the target in any bit is forwarded on `pt_valid`/`pt_addr`/`pt_data` one cycle later with its address and data unchanged, and it sets no status bit. A message that matches the target is never forwarded.
- R7: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a message sets a status bit in the same cycle that software writes 1 to clear that bit, the bit ends up set.
- R9: `irq_out` is high exactly one cycle after a state in which some status bit is 1 while its mask bit is 0.
- R10: `reg_rdata` shows the addressed register one cycle after `reg_rd`, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Inbound memory write present |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number for messages) |
| pt_valid | output | 1 | Forwarded non-message write valid |
| pt_addr | output | 64 | Forwarded write address |
| pt_data | output | 32 | Forwarded write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The bench sends every one of the 256 vectors and checks that only bit v%32 of bank v/32 is set. A design that got the division wrong would light the wrong bank, or two bits. It also aims a message and a status clear at the same bit in the same cycle. A design that let the clear win would lose the interrupt, and one that decoded the clear badly would wipe a neighbouring bit. Data values just past the last vector, addresses that differ in the high word only, and writes to offsets that are not a multiple of 4 are each checked. A design that truncated the data, compared only the low half of the address, or ignored the low address bits would set stray bits or corrupt the enable registers. The mask is checked from both sides: the interrupt line has to stay low with a pending but masked bit, and has to fall once that bit is cleared.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned TGT_LO_OFF  = 'h820;
  localparam int unsigned TGT_HI_OFF  = 'h824;
  localparam int unsigned BANK0_OFF   = 'h828;
  localparam int unsigned BANK_STRIDE = 12;
  localparam int unsigned BANK_BITS   = 32;

  typedef enum logic [1:0] {
    FLD_EN   = 2'd0,
    FLD_MASK = 2'd1,
    FLD_STAT = 2'd2
  } bank_fld_e;

  function automatic int unsigned bank_reg_off(int unsigned bank, int unsigned fld);
    return BANK0_OFF + bank * BANK_STRIDE + fld * 4;
  endfunction
endpackage

// File: rtl/msi_target_regs.sv
module msi_target_regs #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] msg_addr,
  output logic [2*DW-1:0] tgt,
  output logic            match
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

  assign tgt   = {hi_q, lo_q};
  assign match = (msg_addr == tgt);
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int NUM_VEC = 256,
  parameter int DW      = 32
) (
  input  logic               fire,
  input  logic [DW-1:0]      vec,
  output logic               in_range,
  output logic [NUM_VEC-1:0] hit
);
  localparam int VIDX_W = $clog2(NUM_VEC);

  assign in_range = (vec < DW'(NUM_VEC));

  always_comb begin
    hit = '0;
    if (fire && in_range) hit[vec[VIDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_mask,
  input  logic            wr_stat,
  input  logic [BITS-1:0] wdata,
  input  logic [BITS-1:0] hit,
  output logic [BITS-1:0] en_q,
  output logic [BITS-1:0] mask_q,
  output logic [BITS-1:0] stat_q,
  output logic            pend
);
  logic [BITS-1:0] clr;
  logic [BITS-1:0] set;

  assign clr = wr_stat ? wdata : '0;
  assign set = hit & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      // a new message outranks a same-cycle clear
      stat_q <= (stat_q & ~clr) | set;
    end
  end

  assign pend = |(stat_q & ~mask_q);
endmodule

// File: rtl/msi_capture_top.sv
module msi_capture_top #(
  parameter int NUM_BANKS = 8,
  parameter int DW        = 32,
  parameter int REG_AW    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [2*DW-1:0]   msg_addr,
  input  logic [DW-1:0]     msg_data,
  output logic              pt_valid,
  output logic [2*DW-1:0]   pt_addr,
  output logic [DW-1:0]     pt_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out
);
  import msi_cap_pkg::*;

  localparam int BITS    = BANK_BITS;
  localparam int NUM_VEC = NUM_BANKS * BITS;
  localparam logic [REG_AW-1:0] A_LO = REG_AW'(TGT_LO_OFF);
  localparam logic [REG_AW-1:0] A_HI = REG_AW'(TGT_HI_OFF);

  logic [2*DW-1:0]          tgt;
  logic                     match;
  logic                     in_range;
  logic [NUM_VEC-1:0]       hit_all;
  logic [NUM_VEC-1:0]       en_all, mask_all, stat_all;
  logic [NUM_BANKS-1:0]     pend_b;
  logic [NUM_BANKS-1:0][BITS-1:0] en_b, mask_b, stat_b;
  logic [DW-1:0]            rd_word;

  msi_target_regs #(.DW(DW)) u_tgt (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (reg_wr && reg_addr == A_LO),
    .wr_hi    (reg_wr && reg_addr == A_HI),
    .wdata    (reg_wdata),
    .msg_addr (msg_addr),
    .tgt      (tgt),
    .match    (match)
  );

  msi_vec_decode #(.NUM_VEC(NUM_VEC), .DW(DW)) u_dec (
    .fire     (msg_valid && match),
    .vec      (msg_data),
    .in_range (in_range),
    .hit      (hit_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [REG_AW-1:0] A_EN   = REG_AW'(bank_reg_off(b, FLD_EN));
    localparam logic [REG_AW-1:0] A_MASK = REG_AW'(bank_reg_off(b, FLD_MASK));
    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(bank_reg_off(b, FLD_STAT));

    msi_bank #(.BITS(BITS)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_wr && reg_addr == A_EN),
      .wr_mask (reg_wr && reg_addr == A_MASK),
      .wr_stat (reg_wr && reg_addr == A_STAT),
      .wdata   (reg_wdata[BITS-1:0]),
      .hit     (hit_all[b*BITS +: BITS]),
      .en_q    (en_b[b]),
      .mask_q  (mask_b[b]),
      .stat_q  (stat_b[b]),
      .pend    (pend_b[b])
    );

    assign en_all[b*BITS +: BITS]   = en_b[b];
    assign mask_all[b*BITS +: BITS] = mask_b[b];
    assign stat_all[b*BITS +: BITS] = stat_b[b];
  end

  // register read selection
  always_comb begin
    rd_word = '0;
    if (reg_addr == A_LO) rd_word = tgt[DW-1:0];
    if (reg_addr == A_HI) rd_word = tgt[2*DW-1:DW];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == REG_AW'(bank_reg_off(b, FLD_EN)))   rd_word = DW'(en_b[b]);
      if (reg_addr == REG_AW'(bank_reg_off(b, FLD_MASK))) rd_word = DW'(mask_b[b]);
      if (reg_addr == REG_AW'(bank_reg_off(b, FLD_STAT))) rd_word = DW'(stat_b[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
      pt_valid  <= 1'b0;
      pt_addr   <= '0;
      pt_data   <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_word;
      irq_out  <= |pend_b;
      pt_valid <= msg_valid && !match;
      if (msg_valid && !match) begin
        pt_addr <= msg_addr;
        pt_data <= msg_data;
      end
    end
  end

  logic unused_range;
  assign unused_range = in_range;
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int NUM_VEC = 256,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_valid,
  input logic [2*DW-1:0]    msg_addr,
  input logic [DW-1:0]      msg_data,
  input logic [2*DW-1:0]    tgt,
  input logic [NUM_VEC-1:0] en_all,
  input logic [NUM_VEC-1:0] mask_all,
  input logic [NUM_VEC-1:0] stat_all,
  input logic               irq_out,
  input logic               pt_valid,
  input logic [2*DW-1:0]    pt_addr
);
  localparam int VIDX_W = $clog2(NUM_VEC);

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_out && !pt_valid));

  // R2
  p_msg_sets_r2: assert property (@(posedge clk) disable iff (rst)
    $past(msg_valid && msg_addr == tgt && msg_data < DW'(NUM_VEC)
          && en_all[msg_data[VIDX_W-1:0]])
    |-> stat_all[$past(msg_data[VIDX_W-1:0])]);

  // R4, R5: status bits never rise without a message
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(msg_valid) |-> ((stat_all & ~$past(stat_all)) == '0));

  // R6
  p_fwd_addr_r6: assert property (@(posedge clk) disable iff (rst)
    pt_valid |-> (pt_addr == $past(msg_addr) && $past(msg_addr) != $past(tgt)));

  p_match_kept_r6: assert property (@(posedge clk) disable iff (rst)
    $past(msg_valid && msg_addr == tgt) |-> !pt_valid);

  // R9
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(stat_all & ~mask_all)));
endmodule

bind msi_capture_top msi_capture_chk #(.NUM_VEC(NUM_VEC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .tgt       (tgt),
  .en_all    (en_all),
  .mask_all  (mask_all),
  .stat_all  (stat_all),
  .irq_out   (irq_out),
  .pt_valid  (pt_valid),
  .pt_addr   (pt_addr)
);

// File: tb/sim_msi_capture_top.sv
module sim_msi_capture_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        pt_valid;
  logic [63:0] pt_addr;
  logic [31:0] pt_data;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  logic        l_pt_valid;
  logic [63:0] l_pt_addr;
  logic [31:0] l_pt_data;
  logic [31:0] rv;
  localparam logic [63:0] TGT = 64'hFEE0_1234_ABCD_0040;

  always #10 clk = ~clk;

  msi_capture_top u0 (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .pt_valid(pt_valid), .pt_addr(pt_addr),
    .pt_data(pt_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [11:0] ba(int b, int f);
    return 12'('h828 + 12 * b + 4 * f);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    @(negedge clk); msg_valid = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk); msg_valid = 1'b0;
    l_pt_valid = pt_valid; l_pt_addr = pt_addr; l_pt_data = pt_data;
  endtask

  task automatic all_stat_zero(string req);
    logic [31:0] s;
    for (int b = 0; b < 8; b++) begin
      rd(ba(b, 2), s);
      chk(req, s, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs and every register
    chk("R1 irq", irq_out, 0);
    chk("R1 pt_valid", pt_valid, 0);
    for (int a = 'h820; a <= 'h884; a += 4) begin
      rd(12'(a), rv);
      chk("R1 reg", rv, 0);
    end

    // R2: target address registers
    wr(12'h820, TGT[31:0]);
    wr(12'h824, TGT[63:32]);
    rd(12'h820, rv); chk("R2 tgt lo", rv, TGT[31:0]);
    rd(12'h824, rv); chk("R2 tgt hi", rv, TGT[63:32]);

    // R3, R10: layout of enable and mask, read data held
    for (int b = 0; b < 8; b++) begin
      wr(ba(b, 0), 32'hA500_0000 | 32'(b));
      wr(ba(b, 1), 32'h5A00_0000 | 32'(b * 3));
    end
    for (int b = 0; b < 8; b++) begin
      rd(ba(b, 0), rv); chk("R3 enable", rv, 32'hA500_0000 | 32'(b));
      rd(ba(b, 1), rv); chk("R3 mask", rv, 32'h5A00_0000 | 32'(b * 3));
    end
    repeat (3) @(negedge clk);
    chk("R10 rdata held", reg_rdata, 32'h5A00_0000 | 32'(21));
    wr(12'h829, 32'hFFFF_FFFF);
    rd(12'h829, rv); chk("R3 misaligned read", rv, 0);
    rd(ba(0, 0), rv); chk("R3 misaligned write ignored", rv, 32'hA500_0000);
    wr(12'h800, 32'h1234_5678);
    rd(12'h800, rv); chk("R3 unmapped read", rv, 0);

    // R2, R7: exhaustive sweep over all vectors
    for (int b = 0; b < 8; b++) begin
      wr(ba(b, 0), 32'hFFFF_FFFF);
      wr(ba(b, 1), 32'hFFFF_FFFF);
    end
    for (int v = 0; v < 256; v++) begin
      send(TGT, 32'(v));
      chk("R6 match not forwarded", l_pt_valid, 0);
      rd(ba(v / 32, 2), rv);
      chk("R2 vector bit", rv, 32'h1 << (v % 32));
      wr(ba(v / 32, 2), 32'h1 << (v % 32));
      rd(ba(v / 32, 2), rv);
      chk("R7 w1c", rv, 0);
    end

    // R7: zeros leave the bit alone
    send(TGT, 32'd5);
    wr(ba(0, 2), 32'h0);
    rd(ba(0, 2), rv); chk("R7 zero write", rv, 32'h20);
    wr(ba(0, 2), ~32'h20);
    rd(ba(0, 2), rv); chk("R7 other ones", rv, 32'h20);
    wr(ba(0, 2), 32'h20);

    // R4: disabled vector dropped
    wr(ba(1, 0), 32'hFFFF_FFFE);
    send(TGT, 32'd32);
    rd(ba(1, 2), rv); chk("R4 disabled", rv, 0);
    send(TGT, 32'd33);
    rd(ba(1, 2), rv); chk("R4 enabled neighbour", rv, 32'h2);
    wr(ba(1, 2), 32'h2);
    wr(ba(1, 0), 32'hFFFF_FFFF);

    // R5: out-of-range data
    send(TGT, 32'd256);
    chk("R5 not forwarded", l_pt_valid, 0);
    send(TGT, 32'h0000_0103);
    send(TGT, 32'hFFFF_FFFF);
    send(TGT, 32'h8000_0000);
    all_stat_zero("R5 no status");

    // R6: near-miss addresses forwarded
    send(TGT ^ 64'h1, 32'd3);
    chk("R6 fwd valid lo", l_pt_valid, 1);
    chk("R6 fwd addr", l_pt_addr, TGT ^ 64'h1);
    chk("R6 fwd data", l_pt_data, 3);
    send(TGT ^ 64'h8000_0000_0000_0000, 32'd77);
    chk("R6 fwd valid hi", l_pt_valid, 1);
    chk("R6 fwd addr hi", l_pt_addr, TGT ^ 64'h8000_0000_0000_0000);
    @(negedge clk);
    chk("R6 fwd one cycle", pt_valid, 0);
    all_stat_zero("R6 no status");

    // R9: masking and interrupt output
    send(TGT, 32'd70);
    @(negedge clk);
    chk("R9 masked", irq_out, 0);
    wr(ba(2, 1), ~32'h1);
    @(negedge clk);
    chk("R9 unmasked other bit", irq_out, 0);
    wr(ba(2, 1), ~32'h40);
    chk("R9 same edge as mask", irq_out, 0);
    @(negedge clk);
    chk("R9 irq high", irq_out, 1);
    wr(ba(2, 2), 32'h40);
    chk("R9 same edge as clear", irq_out, 1);
    @(negedge clk);
    chk("R9 irq low", irq_out, 0);
    wr(ba(2, 1), 32'hFFFF_FFFF);

    // R8: set wins over same-cycle clear
    send(TGT, 32'd10);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd10;
    reg_wr = 1'b1; reg_addr = ba(0, 2); reg_wdata = 32'h400;
    @(negedge clk);
    msg_valid = 1'b0; reg_wr = 1'b0;
    rd(ba(0, 2), rv); chk("R8 set wins", rv, 32'h400);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = TGT; msg_data = 32'd11;
    reg_wr = 1'b1; reg_addr = ba(0, 2); reg_wdata = 32'h400;
    @(negedge clk);
    msg_valid = 1'b0; reg_wr = 1'b0;
    rd(ba(0, 2), rv); chk("R8 clear one set other", rv, 32'h800);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule